// File: doc/BRIEF.md
# Dual-Rail Complemented Permutation Round

This block is the datapath of a 320-bit lightweight permutation that advances one full round on every enabled clock edge. It holds two copies of the state. The true rail holds the state S. The complement rail holds its bitwise inverse, and it is built from dual gates: AND and OR swap places, XOR and XNOR swap places, and every constant is inverted. The complement rail is never made by inverting the true rail, so a fault that strikes one rail only leaves a visible mismatch between the two. The S-box needs no inverters, because each rail takes the negated terms it needs from the other rail.

The state is five 64-bit words, x0 to x4. A round adds a round constant into x2, applies a 5-bit S-box down each of the 64 bit columns, and then mixes each word with two rotated copies of itself. A precharge strobe sets both rails to all ones. When a complementary state is then loaded, or the first round runs, each bit pair makes a single falling transition. A surrounding controller supplies the round index and reads the 128-bit tag pair. It can XOR the two tags together: any bit that is not one marks a fault.

Top module: `dr_perm_round`

## Requirements
- R1: While reset is asserted, and on leaving it, every bit of both state rails and both tags is 1.
- R2: A clock edge with `precharge_i` high sets both rails to all ones. This takes priority over `load_i` and `enable_i`.
- R3: An edge with `load_i` high and `precharge_i` low copies `init_s_i` into the true rail and `init_sn_i` into the complement rail. This takes priority over `enable_i`.
- R4: An edge with `enable_i` high and the other two strobes low replaces the true rail with one round of the permutation, using the round index `round_i`. The state bus packs x0 in bits 319:256, x1 in bits 255:192, x2 in bits 191:128, x3 in bits 127:64 and x4 in bits 63:0. The S-box column j takes bit j of each word. The rotations to the right are (19,28) for x0, (61,39) for x1, (1,6) for x2, (10,17) for x3 and (7,41) for x4.
- R5: For a round index i from 0 to 15, the constant XORed into the low byte of x2 is ((15-i)<<4)|i. Every index, including 12 to 15, follows this formula.
- R6: If the two rails are exact complements before a round, they are exact complements after it.
- R7: An edge with all three strobes low leaves both rails unchanged.
- R8: `tag_o` equals bits 127:0 of the true rail, which are {x3,x4}. `tagn_o` equals the same bits of the complement rail. Whenever the rails are complementary, `tag_o ^ tagn_o` is all ones.
- R9: Loading a complementary pair from the precharged state leaves exactly one 0 in every bit pair, and no bit rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, to all ones |
| precharge_i | input | 1 | Sets both rails to all ones |
| load_i | input | 1 | Loads the initial state pair |
| enable_i | input | 1 | Runs one round on both rails |
| round_i | input | 4 | Round index used to pick the round constant |
| init_s_i | input | 320 | Initial true state |
| init_sn_i | input | 320 | Initial complement state |
| s_o | output | 320 | True-rail state |
| sn_o | output | 320 | Complement-rail state |
| tag_o | output | 128 | True tag, {x3,x4} |
| tagn_o | output | 128 | Complement tag |

## Verification
The bench builds the block with its default parameters: 64-bit words and a 4-bit round index. This makes the whole round-index space of 16 values small enough to sweep on several states, including the all-zero state, where the constant is the only input that is not zero. A full 12-round run is compared each cycle against a word-level model computed in the bench. Strobe-priority and hold cases, and a deliberately non-complementary load, show that the tag pair reports a rail mismatch.

// File: rtl/dr_perm_pkg.sv
package dr_perm_pkg;
   localparam int unsigned NUM_WORDS = 5;

   // rotate-right amounts of the linear layer, first pair element
   function automatic int unsigned rot_first(input int unsigned w);
      case (w)
         0: return 19;
         1: return 61;
         2: return 1;
         3: return 10;
         default: return 7;
      endcase
   endfunction

   // rotate-right amounts of the linear layer, second pair element
   function automatic int unsigned rot_second(input int unsigned w);
      case (w)
         0: return 28;
         1: return 39;
         2: return 6;
         3: return 17;
         default: return 41;
      endcase
   endfunction
endpackage

// File: rtl/dr_sbox_col.sv
// One 5-bit S-box column evaluated on both rails. Bit k of each vector is word xk.
// Negated terms of one rail are taken from the other rail, so no inverter appears.
module dr_sbox_col (
   input  logic [4:0] t_i,
   input  logic [4:0] c_i,
   output logic [4:0] t_o,
   output logic [4:0] c_o
);
   logic [4:0] tp, cp;   // after input mixing
   logic [4:0] tk, ck;   // nonlinear terms
   logic [4:0] tr, cr;   // after nonlinear layer

   always_comb begin
      tp[0] = t_i[0] ^ t_i[4];
      tp[1] = t_i[1];
      tp[2] = t_i[2] ^ t_i[1];
      tp[3] = t_i[3];
      tp[4] = t_i[4] ^ t_i[3];
      cp[0] = c_i[0] ~^ c_i[4];
      cp[1] = c_i[1];
      cp[2] = c_i[2] ~^ c_i[1];
      cp[3] = c_i[3];
      cp[4] = c_i[4] ~^ c_i[3];
   end

   for (genvar k = 0; k < 5; k++) begin : g_chi
      localparam int unsigned KN = (k + 1) % 5;
      // true rail: (not a_k) and a_k+1, the negation comes from the complement rail
      assign tk[k] = cp[k] & tp[KN];
      // dual: a_k or (not a_k+1)
      assign ck[k] = tp[k] | cp[KN];
   end

   for (genvar k = 0; k < 5; k++) begin : g_mix
      localparam int unsigned KN = (k + 1) % 5;
      assign tr[k] = tp[k] ^ tk[KN];
      assign cr[k] = cp[k] ~^ ck[KN];
   end

   always_comb begin
      t_o[0] = tr[0] ^ tr[4];
      t_o[1] = tr[1] ^ tr[0];
      t_o[2] = cr[2];           // final inversion: swap rails
      t_o[3] = tr[3] ^ tr[2];
      t_o[4] = tr[4];
      c_o[0] = cr[0] ~^ cr[4];
      c_o[1] = cr[1] ~^ cr[0];
      c_o[2] = tr[2];
      c_o[3] = cr[3] ~^ cr[2];
      c_o[4] = cr[4];
   end
endmodule

// File: rtl/dr_diffuse_word.sv
// Linear mixing of one word on both rails: x ^ ror(x,A) ^ ror(x,B) and its dual.
module dr_diffuse_word #(
   parameter int unsigned WORD_W = 64,
   parameter int unsigned ROT_A  = 19,
   parameter int unsigned ROT_B  = 28
) (
   input  logic [WORD_W-1:0] t_i,
   input  logic [WORD_W-1:0] c_i,
   output logic [WORD_W-1:0] t_o,
   output logic [WORD_W-1:0] c_o
);
   if (ROT_A == 0 || ROT_A >= WORD_W || ROT_B == 0 || ROT_B >= WORD_W) begin : g_bad_rot
      $error("dr_diffuse_word: rotation amount out of range");
   end

   logic [WORD_W-1:0] t_ra, t_rb, c_ra, c_rb;

   assign t_ra = {t_i[ROT_A-1:0], t_i[WORD_W-1:ROT_A]};
   assign t_rb = {t_i[ROT_B-1:0], t_i[WORD_W-1:ROT_B]};
   assign c_ra = {c_i[ROT_A-1:0], c_i[WORD_W-1:ROT_A]};
   assign c_rb = {c_i[ROT_B-1:0], c_i[WORD_W-1:ROT_B]};

   assign t_o = t_i ^ t_ra ^ t_rb;
   assign c_o = (c_i ~^ c_ra) ~^ c_rb;
endmodule

// File: rtl/dr_round.sv
// Combinational round on both rails: constant addition, S-box layer, linear layer.
module dr_round
   import dr_perm_pkg::*;
#(
   parameter int unsigned WORD_W = 64,
   parameter int unsigned RIDX_W = 4,
   localparam int unsigned STATE_W = NUM_WORDS * WORD_W,
   localparam int unsigned RC_W    = 2 * RIDX_W
) (
   input  logic [RIDX_W-1:0]  round_i,
   input  logic [STATE_W-1:0] t_i,
   input  logic [STATE_W-1:0] c_i,
   output logic [STATE_W-1:0] t_o,
   output logic [STATE_W-1:0] c_o
);
   if (RC_W > WORD_W) begin : g_bad_rc
      $error("dr_round: round constant wider than a word");
   end

   localparam logic [RIDX_W-1:0] IDX_MAX = {RIDX_W{1'b1}};

   typedef logic [WORD_W-1:0] word_t;

   word_t tw [NUM_WORDS];
   word_t cw [NUM_WORDS];
   word_t ta [NUM_WORDS];   // after constant addition
   word_t ca [NUM_WORDS];
   word_t ts [NUM_WORDS];   // after S-box layer
   word_t cs [NUM_WORDS];
   word_t tl [NUM_WORDS];   // after linear layer
   word_t cl [NUM_WORDS];

   logic [RC_W-1:0] rc;
   word_t           rc_t;   // constant for the true rail
   word_t           rc_c;   // dual constant for the complement rail

   assign rc   = {IDX_MAX - round_i, round_i};
   assign rc_t = word_t'(rc);
   assign rc_c = ~rc_t;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_split
      localparam int unsigned HI = STATE_W - 1 - w * WORD_W;
      assign tw[w] = t_i[HI -: WORD_W];
      assign cw[w] = c_i[HI -: WORD_W];
      if (w == 2) begin : g_rc
         assign ta[w] = tw[w] ^ rc_t;
         assign ca[w] = cw[w] ~^ rc_c;
      end else begin : g_pass
         assign ta[w] = tw[w];
         assign ca[w] = cw[w];
      end
   end

   for (genvar j = 0; j < WORD_W; j++) begin : g_col
      logic [4:0] tcol_i, ccol_i, tcol_o, ccol_o;
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_gather
         assign tcol_i[w]   = ta[w][j];
         assign ccol_i[w]   = ca[w][j];
         assign ts[w][j]    = tcol_o[w];
         assign cs[w][j]    = ccol_o[w];
      end
      dr_sbox_col u_sbox (
         .t_i (tcol_i),
         .c_i (ccol_i),
         .t_o (tcol_o),
         .c_o (ccol_o)
      );
   end

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_lin
      localparam int unsigned HI = STATE_W - 1 - w * WORD_W;
      dr_diffuse_word #(
         .WORD_W (WORD_W),
         .ROT_A  (rot_first(w)),
         .ROT_B  (rot_second(w))
      ) u_diff (
         .t_i (ts[w]),
         .c_i (cs[w]),
         .t_o (tl[w]),
         .c_o (cl[w])
      );
      assign t_o[HI -: WORD_W] = tl[w];
      assign c_o[HI -: WORD_W] = cl[w];
   end
endmodule

// File: rtl/dr_state_reg.sv
// State pair register with precharge > load > enable priority. Reset value is all ones.
module dr_state_reg #(
   parameter int unsigned STATE_W = 320
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               precharge_i,
   input  logic               load_i,
   input  logic               enable_i,
   input  logic [STATE_W-1:0] init_t_i,
   input  logic [STATE_W-1:0] init_c_i,
   input  logic [STATE_W-1:0] next_t_i,
   input  logic [STATE_W-1:0] next_c_i,
   output logic [STATE_W-1:0] t_q,
   output logic [STATE_W-1:0] c_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_q <= '1;
         c_q <= '1;
      end else if (precharge_i) begin
         t_q <= '1;
         c_q <= '1;
      end else if (load_i) begin
         t_q <= init_t_i;
         c_q <= init_c_i;
      end else if (enable_i) begin
         t_q <= next_t_i;
         c_q <= next_c_i;
      end
   end

   a_r2_precharge_ones: assert property (@(posedge clk) disable iff (!rst_n)
      precharge_i |=> (&t_q) && (&c_q));

   a_r3_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !precharge_i) |=> (t_q == $past(init_t_i)) && (c_q == $past(init_c_i)));

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!precharge_i && !load_i && !enable_i) |=> $stable(t_q) && $stable(c_q));

   a_r9_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !precharge_i && (&t_q) && (&c_q) && (&(init_t_i ^ init_c_i)))
      |=> &(t_q ^ c_q));
endmodule

// File: rtl/dr_perm_round.sv
module dr_perm_round
   import dr_perm_pkg::*;
#(
   parameter int unsigned WORD_W = 64,
   parameter int unsigned RIDX_W = 4,
   parameter int unsigned TAG_W  = 128,
   localparam int unsigned STATE_W = NUM_WORDS * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               precharge_i,
   input  logic               load_i,
   input  logic               enable_i,
   input  logic [RIDX_W-1:0]  round_i,
   input  logic [STATE_W-1:0] init_s_i,
   input  logic [STATE_W-1:0] init_sn_i,
   output logic [STATE_W-1:0] s_o,
   output logic [STATE_W-1:0] sn_o,
   output logic [TAG_W-1:0]   tag_o,
   output logic [TAG_W-1:0]   tagn_o
);
   if (WORD_W != 64) begin : g_bad_word
      $error("dr_perm_round: rotation set requires 64-bit words");
   end
   if (TAG_W > 2 * WORD_W) begin : g_bad_tag
      $error("dr_perm_round: tag wider than the two last words");
   end

   logic [STATE_W-1:0] nxt_t, nxt_c;

   dr_round #(
      .WORD_W (WORD_W),
      .RIDX_W (RIDX_W)
   ) u_round (
      .round_i (round_i),
      .t_i     (s_o),
      .c_i     (sn_o),
      .t_o     (nxt_t),
      .c_o     (nxt_c)
   );

   dr_state_reg #(
      .STATE_W (STATE_W)
   ) u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .precharge_i (precharge_i),
      .load_i      (load_i),
      .enable_i    (enable_i),
      .init_t_i    (init_s_i),
      .init_c_i    (init_sn_i),
      .next_t_i    (nxt_t),
      .next_c_i    (nxt_c),
      .t_q         (s_o),
      .c_q         (sn_o)
   );

   assign tag_o  = s_o[TAG_W-1:0];
   assign tagn_o = sn_o[TAG_W-1:0];

   a_r6_pair_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && !precharge_i && !load_i && (s_o == ~sn_o)) |=> (s_o == ~sn_o));

   a_r8_tag_check: assert property (@(posedge clk) disable iff (!rst_n)
      (s_o == ~sn_o) |-> &(tag_o ^ tagn_o));

   a_r1_reset_ones: assert property (@(posedge clk)
      $rose(rst_n) |-> (&s_o) && (&sn_o));
endmodule

// File: tb/sim_dr_perm_round.sv
module sim_dr_perm_round;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         precharge_i = 1'b0;
   logic         load_i = 1'b0;
   logic         enable_i = 1'b0;
   logic [3:0]   round_i = '0;
   logic [319:0] init_s_i = '0;
   logic [319:0] init_sn_i = '0;
   logic [319:0] s_o, sn_o;
   logic [127:0] tag_o, tagn_o;

   int n_chk = 0;
   int n_fail = 0;
   logic [63:0] seed = 64'h9E3779B97F4A7C15;

   always #2.5 clk = ~clk;

   dr_perm_round u0 (
      .clk (clk), .rst_n (rst_n), .precharge_i (precharge_i), .load_i (load_i),
      .enable_i (enable_i), .round_i (round_i), .init_s_i (init_s_i),
      .init_sn_i (init_sn_i), .s_o (s_o), .sn_o (sn_o), .tag_o (tag_o), .tagn_o (tagn_o)
   );

   function automatic logic [63:0] ror(input logic [63:0] x, input int n);
      return (x >> n) | (x << (64 - n));
   endfunction

   // word-level model of one round, from the requirements
   function automatic logic [319:0] model(input logic [319:0] st, input int i);
      logic [63:0] x0, x1, x2, x3, x4, t0, t1, t2, t3, t4;
      x0 = st[319:256]; x1 = st[255:192]; x2 = st[191:128]; x3 = st[127:64]; x4 = st[63:0];
      x2 = x2 ^ {56'd0, 4'(15 - i), 4'(i)};
      x0 ^= x4; x4 ^= x3; x2 ^= x1;
      t0 = ~x0 & x1; t1 = ~x1 & x2; t2 = ~x2 & x3; t3 = ~x3 & x4; t4 = ~x4 & x0;
      x0 ^= t1; x1 ^= t2; x2 ^= t3; x3 ^= t4; x4 ^= t0;
      x1 ^= x0; x0 ^= x4; x3 ^= x2; x2 = ~x2;
      x0 = x0 ^ ror(x0, 19) ^ ror(x0, 28);
      x1 = x1 ^ ror(x1, 61) ^ ror(x1, 39);
      x2 = x2 ^ ror(x2, 1)  ^ ror(x2, 6);
      x3 = x3 ^ ror(x3, 10) ^ ror(x3, 17);
      x4 = x4 ^ ror(x4, 7)  ^ ror(x4, 41);
      return {x0, x1, x2, x3, x4};
   endfunction

   function automatic logic [63:0] nxt64();
      seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17;
      return seed;
   endfunction

   task automatic chk(input string req, input logic [319:0] act, input logic [319:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic edge1();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic strobes(input logic p, input logic l, input logic e);
      precharge_i = p; load_i = l; enable_i = e;
   endtask

   task automatic check_pair(input string req, input logic [319:0] exp);
      chk({req, " true"}, s_o, exp);
      chk({req, " comp"}, sn_o, ~exp);
      chk({req, " R8 tag"}, {192'd0, tag_o}, {192'd0, exp[127:0]});
      chk({req, " R8 tagxor"}, {192'd0, tag_o ^ tagn_o}, {192'd0, {128{1'b1}}});
   endtask

   logic [319:0] st, prev;

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      chk("R1 reset true", s_o, '1);
      chk("R1 reset comp", sn_o, '1);
      rst_n = 1'b1;
      edge1();
      chk("R1 after reset", s_o & sn_o, '1);

      // R9: load complementary pair from precharged state
      st = {nxt64(), nxt64(), nxt64(), nxt64(), nxt64()};
      init_s_i = st; init_sn_i = ~st;
      prev = s_o;
      strobes(0, 1, 1);   // R3 load wins over enable
      edge1();
      check_pair("R3 load", st);
      chk("R9 no rise true", s_o & ~prev, '0);
      chk("R9 one zero per pair", s_o ^ sn_o, '1);

      // R4/R6: full 12-round run
      strobes(0, 0, 1);
      for (int i = 0; i < 12; i++) begin
         round_i = 4'(i);
         edge1();
         st = model(st, i);
         check_pair("R4 R6 round", st);
      end

      // R7: hold
      strobes(0, 0, 0);
      round_i = 4'd3;
      for (int k = 0; k < 3; k++) begin
         edge1();
         check_pair("R7 hold", st);
      end

      // R5: sweep every round index on zero and random states
      for (int v = 0; v < 4; v++) begin
         for (int i = 0; i < 16; i++) begin
            if (v == 0) st = '0;
            else st = {nxt64(), nxt64(), nxt64(), nxt64(), nxt64()};
            init_s_i = st; init_sn_i = ~st;
            strobes(0, 1, 0);
            edge1();
            strobes(0, 0, 1);
            round_i = 4'(i);
            edge1();
            check_pair("R5 index sweep", model(st, i));
         end
      end

      // R2: precharge beats load and enable
      strobes(1, 1, 1);
      edge1();
      chk("R2 precharge true", s_o, '1);
      chk("R2 precharge comp", sn_o, '1);

      // R8: non-complementary load shows up in the tag pair
      st = {nxt64(), nxt64(), nxt64(), nxt64(), nxt64()};
      init_s_i = st; init_sn_i = ~st ^ 320'd1;
      strobes(0, 1, 0);
      edge1();
      chk("R8 fault flagged", {192'd0, tag_o ^ tagn_o}, {192'd0, {127{1'b1}}, 1'b0});
      strobes(0, 0, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule